// File: doc/BRIEF.md
# Shift-Add Golden-Ratio Hash Unit

This block turns a 32-bit key into a hash by multiplying it, modulo 2^32, by the odd constant 0x61C88647. It has no hardware multiplier. The product is assembled from three shared partial terms built only from shifts and additions. A single subtraction in the final combine removes one of those terms. The work is split across two register stages, so a new key can enter on every clock.

The hash is the upper `HASH_BITS` bits of the 32-bit product, which is the usual way to index a table of 2^N buckets with a multiplicative hash. A key arrives with a valid flag, and the matching hash leaves with its own valid flag two cycles later. There is no backpressure. The consumer must take each result in the cycle it appears.

Top module: `golden_hash`

## Requirements
- R1: With `HASH_BITS` = 32, every valid result on `out_hash` equals `(in_key * 0x61C88647) mod 2^32` for the key that produced it.
- R2: With `HASH_BITS` = N below 32, `out_hash` equals that 32-bit product shifted right by 32 - N, which gives its N most significant bits.
- R3: `out_valid` is high in a cycle exactly when `in_valid` was high two cycles earlier and no reset intervened, so the latency is exactly 2 cycles.
- R4: Keys presented on consecutive cycles each produce a correct result on consecutive cycles, in the order the keys arrived.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low two cycles later, even when its neighbours are valid.
- R6: A synchronous active-high `rst` clears every valid flag. `out_valid` is low in the cycle after any cycle with `rst` high, and keys still in flight when reset is sampled never come out.
- R7: Boundary keys wrap correctly: key 0 hashes to 0, key 1 to 0x61C88647, key 0xFFFFFFFF to 0x9E3779B9, and key 0x80000000 to 0x80000000 (all full 32-bit products, then truncated as in R2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Key on `in_key` is to be hashed this cycle |
| in_key | input | 32 | Key to hash |
| out_valid | output | 1 | `out_hash` carries a result this cycle |
| out_hash | output | HASH_BITS | Upper `HASH_BITS` bits of the wrapped product |

## Verification
The bench builds two copies side by side and feeds both the same stimulus. One copy uses `HASH_BITS` = 32 and exposes the whole wrapped product, so an error in any shift amount or in the final subtraction appears in the output bits. The other uses `HASH_BITS` = 5, which exercises the right-shift selection and shows that only the carries reaching the top bits matter there. Both copies see back-to-back keys, bubbles, the four wrap-around keys and a reset taken while keys are in flight.

// File: rtl/golden_hash_pkg.sv
package golden_hash_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] GOLD_K = 32'h61C88647;

  // partial-term shifts (first phase)
  localparam int SH_A = 19;
  localparam int SH_B = 9;
  localparam int SH_C = 23;
  // combine shifts (second phase)
  localparam int SH_FB = 11;
  localparam int SH_FC = 6;
  localparam int SH_FA = 3;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
  } terms_t;
endpackage

// File: rtl/golden_hash_expand.sv
module golden_hash_expand
  import golden_hash_pkg::*;
(
  input  word_t  key,
  output terms_t terms
);
  // a = k(2^19+1); b = a + k*2^9; c = b + k*2^23
  always_comb begin
    terms.a = (key << SH_A) + key;
    terms.b = (key << SH_B) + terms.a;
    terms.c = (key << SH_C) + terms.b;
  end
endmodule

// File: rtl/golden_hash_fold.sv
module golden_hash_fold
  import golden_hash_pkg::*;
(
  input  terms_t terms,
  output word_t  product
);
  // b*2^11 + c*(2^6-1) + a*2^3, all wrapping mod 2^32
  always_comb begin
    product = (terms.b << SH_FB) + (terms.c << SH_FC) + (terms.a << SH_FA) - terms.c;
  end
endmodule

// File: rtl/golden_hash_trim.sv
module golden_hash_trim
  import golden_hash_pkg::*;
#(
  parameter int HASH_BITS = 32
) (
  input  word_t                 product,
  output logic [HASH_BITS-1:0]  hash
);
  generate
    if (HASH_BITS == WORD_W) begin : g_full
      assign hash = product;
    end else begin : g_top
      assign hash = product[WORD_W-1 -: HASH_BITS];
    end
  endgenerate
endmodule

// File: rtl/golden_hash.sv
module golden_hash
  import golden_hash_pkg::*;
#(
  parameter int HASH_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [31:0]           in_key,
  output logic                  out_valid,
  output logic [HASH_BITS-1:0]  out_hash
);
  generate
    if (HASH_BITS < 1 || HASH_BITS > WORD_W) begin : g_bad_width
      $error("golden_hash: HASH_BITS out of range");
    end
  endgenerate

  terms_t                terms_d;
  terms_t                terms_q;
  logic                  mid_valid;
  word_t                 product_d;
  logic [HASH_BITS-1:0]  hash_d;

  // phase one: three shared partial terms
  golden_hash_expand u_expand (
    .key   (in_key),
    .terms (terms_d)
  );

  always_ff @(posedge clk) begin
    terms_q <= terms_d;
    if (rst) mid_valid <= 1'b0;
    else     mid_valid <= in_valid;
  end

  // phase two: combine and keep the top bits
  golden_hash_fold u_fold (
    .terms   (terms_q),
    .product (product_d)
  );

  golden_hash_trim #(.HASH_BITS(HASH_BITS)) u_trim (
    .product (product_d),
    .hash    (hash_d)
  );

  always_ff @(posedge clk) begin
    out_hash <= hash_d;
    if (rst) out_valid <= 1'b0;
    else     out_valid <= mid_valid;
  end
endmodule

// File: rtl/golden_hash_chk.sv
module golden_hash_chk
  import golden_hash_pkg::*;
#(
  parameter int HASH_BITS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [31:0]          in_key,
  input logic                 mid_valid,
  input logic                 out_valid,
  input logic [HASH_BITS-1:0] out_hash
);
  function automatic logic [HASH_BITS-1:0] ref_hash(input logic [31:0] x);
    logic [63:0] p;
    logic [31:0] s;
    p = {32'd0, x} * {32'd0, GOLD_K};
    s = p[31:0] >> (WORD_W - HASH_BITS);
    return s[HASH_BITS-1:0];
  endfunction

  // R1 R2
  hash_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hash == ref_hash($past(in_key, 2))));

  // R3
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

  // R3
  mid_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mid_valid == $past(in_valid)));

  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid, 2) |-> !out_valid);

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !mid_valid));
endmodule

bind golden_hash golden_hash_chk #(.HASH_BITS(HASH_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_key    (in_key),
  .mid_valid (mid_valid),
  .out_valid (out_valid),
  .out_hash  (out_hash)
);

// File: tb/golden_hash_bench.sv
module golden_hash_bench;
  localparam int NB = 5;
  localparam logic [31:0] K = 32'h61C88647;
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h80000000, 32'h00000002,
    32'h7FFFFFFF, 32'hDEADBEEF, 32'h12345678, 32'h00010000, 32'hFFFF0000
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_key = 32'd0;
  logic        w_vld;
  logic [31:0] w_hash;
  logic        n_vld;
  logic [NB-1:0] n_hash;

  int checks = 0;
  int errors = 0;
  logic        h_v [2] = '{1'b0, 1'b0};
  logic [31:0] h_k [2] = '{32'd0, 32'd0};

  always #10 clk = ~clk;

  golden_hash #(.HASH_BITS(32)) u_golden_hash (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key),
    .out_valid(w_vld), .out_hash(w_hash)
  );

  golden_hash #(.HASH_BITS(NB)) u_golden_hash_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key),
    .out_valid(n_vld), .out_hash(n_hash)
  );

  function automatic logic [31:0] ref_full(input logic [31:0] x);
    logic [63:0] p;
    p = {32'd0, x} * {32'd0, K};
    return p[31:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // one cycle: check outputs at the falling edge, then drive the next inputs
  task automatic step(input logic r, input logic v, input logic [31:0] k, input string tag);
    @(negedge clk);
    chk($sformatf("R3 %s valid", tag), {31'd0, w_vld}, {31'd0, h_v[1]});
    chk($sformatf("R3 %s narrow valid", tag), {31'd0, n_vld}, {31'd0, h_v[1]});
    if (h_v[1]) begin
      chk($sformatf("R1 %s", tag), w_hash, ref_full(h_k[1]));
      chk($sformatf("R2 %s", tag), {27'd0, n_hash}, ref_full(h_k[1]) >> (32 - NB));
    end
    h_v[1] = r ? 1'b0 : h_v[0];
    h_k[1] = h_k[0];
    h_v[0] = v && !r;
    h_k[0] = k;
    rst      = r;
    in_valid = v;
    in_key   = k;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] corner_k [4];
    logic [31:0] corner_e [4];
    corner_k = '{32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h80000000};
    corner_e = '{32'h00000000, 32'h61C88647, 32'h9E3779B9, 32'h80000000};

    // R6: reset held with valid input produces nothing
    rst = 1'b1; in_valid = 1'b1; in_key = 32'h5A5A5A5A;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 32'h5A5A5A5A, "R6 reset");
    step(1'b0, 1'b0, 32'd0, "R6 release");
    step(1'b0, 1'b0, 32'd0, "R6 release");

    // R4: table walked back to back
    for (int i = 0; i < NV; i++) step(1'b0, 1'b1, VEC[i], "R4 table");
    step(1'b0, 1'b0, 32'd0, "R5 drain");
    step(1'b0, 1'b0, 32'd0, "R5 drain");

    // R7: wrap-around keys against literal products
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1, corner_k[i], "R7 corner");
      step(1'b0, 1'b0, 32'd0, "R7 corner");
      step(1'b0, 1'b0, 32'd0, "R7 corner");
      chk("R7 corner full", w_hash, corner_e[i]);
      chk("R7 corner narrow", {27'd0, n_hash}, corner_e[i] >> (32 - NB));
    end

    // R5: random keys with bubbles
    for (int i = 0; i < 24; i++) begin
      logic [31:0] rk;
      rk = $urandom;
      step(1'b0, (i % 3) != 1, rk, "R5 random");
    end
    step(1'b0, 1'b0, 32'd0, "R5 drain");
    step(1'b0, 1'b0, 32'd0, "R5 drain");

    // R6: reset taken while two keys are in flight
    step(1'b0, 1'b1, 32'hCAFEF00D, "R6 inflight");
    step(1'b0, 1'b1, 32'h0BADC0DE, "R6 inflight");
    step(1'b1, 1'b0, 32'd0, "R6 inflight");
    step(1'b0, 1'b0, 32'd0, "R6 inflight");
    step(1'b0, 1'b0, 32'd0, "R6 inflight");
    step(1'b0, 1'b0, 32'd0, "R6 inflight");

    // R4: streaming resumes after reset
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 32'h01000193 * (i + 1), "R4 resume");
    step(1'b0, 1'b0, 32'd0, "R4 drain");
    step(1'b0, 1'b0, 32'd0, "R4 drain");
    step(1'b0, 1'b0, 32'd0, "R4 drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule